// File: doc/BRIEF.md
# Stereo Filter Mode Sequencer

This block is the top-level sequencer of a two-channel FIR audio processor. It takes the chip from power-up through memory clearing. It then loads the filter set-up, first a short table of group counts and then the coefficient words. After that it waits for audio and runs continuous filtering. The datapath never shifts a bit or does arithmetic here; the sequencer only tells the loaders and the compute engine when to act and where to write. It also decides when the host may send data.

A host handshake line (`in_ready_o`) tells the controller when streaming is allowed. Frame pulses from the host move the sequencer from each waiting mode into the mode that follows it. Word-valid strobes from the deserialiser are counted to know when each table is full. The host can apply a soft reset at any time once the tables are loaded. The soft reset clears sample and output history but leaves the filter set-up in place. A long run of silence on both channels parks the engine in a sleep mode, and the first non-silent word wakes it again.

Top module: `audio_mode_ctrl`

## Requirements
- R1: After the asynchronous reset, `mode_o` is 0. `in_ready_o`, `mem_clr_o`, `samp_clr_o` and all three enables are low. The mode codes are: 0 init, 1 wait-groups, 2 load-groups, 3 wait-coefs, 4 load-coefs, 5 wait-data, 6 run, 7 hold, 8 sleep.
- R2: A `start_i` pulse in mode 0 drives `mem_clr_o` high for exactly CLR_CYCLES cycles (default 256), with `in_ready_o` low during that time. Mode 1 follows immediately, with `in_ready_o` high.
- R3: A frame pulse in mode 1 enters mode 2, where `grp_ld_en_o` is high. `ld_idx_o` starts at 0 and rises by one per word strobe. The GRP_WORDS-th strobe (default 16) moves to mode 3.
- R4: A frame pulse in mode 3 enters mode 4, where `coef_ld_en_o` is high and `ld_idx_o` counts from 0. The COEF_WORDS-th strobe (default 256, one word on each channel per strobe) moves to mode 5.
- R5: A frame pulse in mode 5 enters mode 6, where `compute_en_o` is high. `in_ready_o` is high in modes 1 to 6 and in mode 8.
- R6: `host_rst_n_i` low in mode 5, 6 or 8 enters mode 7 on the next edge. This takes priority over frame, sleep and wake. Mode 7 holds `in_ready_o` low and `samp_clr_o` high, and keeps `mem_clr_o` low so the set-up tables survive. It stays in mode 7 while `host_rst_n_i` is low, and returns to mode 5 on the first edge where it is high.
- R7: `host_rst_n_i` low in modes 0 to 4 has no effect: the mode and the load index carry on as if it were high.
- R8: In mode 6, a strobe on which both channel words are zero extends a silence run, and a strobe with any nonzero word restarts it. The strobe that completes ZERO_RUN consecutive silent strobes (default 800) moves to mode 8.
- R9: In mode 8, `compute_en_o` is low and `in_ready_o` high. Silent strobes keep mode 8. A strobe with a nonzero word on either channel returns to mode 6.
- R10: The silence run starts from zero each time mode 6 is entered, so silent strobes counted before a soft reset do not count afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low chip reset, released synchronously inside |
| start_i | input | 1 | Begins memory clearing in mode 0 |
| frame_i | input | 1 | Host frame pulse marking the first bit of a word |
| host_rst_n_i | input | 1 | Host soft reset, active low |
| word_vld_i | input | 1 | One complete word is present on each channel |
| samp_l_i | input | SAMP_W | Left-channel word for the current strobe |
| samp_r_i | input | SAMP_W | Right-channel word for the current strobe |
| in_ready_o | output | 1 | Host may stream clock, frame and data |
| mem_clr_o | output | 1 | Clear all sample, group-count and coefficient memories |
| samp_clr_o | output | 1 | Clear sample history and output state only |
| grp_ld_en_o | output | 1 | Group-count loader writes at `ld_idx_o` |
| coef_ld_en_o | output | 1 | Coefficient loader writes at `ld_idx_o` |
| compute_en_o | output | 1 | Filter engine runs |
| ld_idx_o | output | clog2(COEF_WORDS) | Write index for the active loader |
| mode_o | output | 4 | Current mode code (see R1) |

## Verification
Every mode decision appears on `mode_o` on the edge after its cause, so a wrong next-state choice shows within one cycle. A load index that counts wrong shifts the move out of mode 2 or 4 by whole strobes. That error shows up only on the final word of a table, so the index is also compared at every strobe. A silence counter that is off by one, or that is not cleared on re-entry to mode 6, moves sleep entry by a strobe or by a whole earlier run. That is exposed by runs of 799, 800 and split 500+300 silent strobes. A soft reset that wiped the tables would raise `mem_clr_o` in mode 7, which is observed directly.

// File: rtl/amc_pkg.sv
`timescale 1ns/1ps
package amc_pkg;

  typedef enum logic [3:0] {
    MD_INIT      = 4'd0,
    MD_WAIT_GRP  = 4'd1,
    MD_LOAD_GRP  = 4'd2,
    MD_WAIT_COEF = 4'd3,
    MD_LOAD_COEF = 4'd4,
    MD_WAIT_DATA = 4'd5,
    MD_RUN       = 4'd6,
    MD_HOLD      = 4'd7,
    MD_SLEEP     = 4'd8
  } mode_e;

  localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/amc_rst_sync.sv
`timescale 1ns/1ps
module amc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/amc_clear_seq.sv
`timescale 1ns/1ps
module amc_clear_seq #(
  parameter int unsigned CLR_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned CNT_W = (CLR_CYCLES > 1) ? $clog2(CLR_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLR_CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done_o = busy_q && (cnt_q == LAST);
  assign cnt_en = busy_q || (arm_i && start_i);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (!busy_q) begin
      if (arm_i && start_i) begin
        busy_d = 1'b1;
        cnt_d  = '0;
      end
    end else if (done_o) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;

  assert_clr_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (busy_q ? (cnt_q == $past(cnt_q) + 1'b1) : $past(done_o)))
    else $error("clear sequence stepped out of order");

endmodule

// File: rtl/amc_word_count.sv
`timescale 1ns/1ps
module amc_word_count #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [IDX_W-1:0] idx_o
);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  assign idx_en = clr_i || inc_i;

  always_comb begin
    if (clr_i) idx_d = '0;
    else       idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx_o = idx_q;

endmodule

// File: rtl/amc_zero_run.sv
`timescale 1ns/1ps
module amc_zero_run #(
  parameter int unsigned ZERO_RUN = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic vld_i,
  input  logic silent_i,
  output logic hit_o
);

  localparam int unsigned CNT_W = $clog2(ZERO_RUN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ZERO_RUN - 1);

  logic [CNT_W-1:0] run_q, run_d;
  logic             run_en;

  assign hit_o  = active_i && vld_i && silent_i && (run_q == LAST);
  assign run_en = !active_i || vld_i;

  always_comb begin
    if (!active_i || !silent_i) run_d = '0;
    else if (hit_o)             run_d = '0;
    else                        run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  assert_run_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && vld_i && !silent_i) |=> (run_q == '0))
    else $error("silence run not restarted by nonzero word");

  assert_run_fresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i) |=> (run_q == '0))
    else $error("silence run survived leaving run mode");

endmodule

// File: rtl/audio_mode_ctrl.sv
`timescale 1ns/1ps
module audio_mode_ctrl
  import amc_pkg::*;
#(
  parameter int unsigned SAMP_W     = 16,
  parameter int unsigned GRP_WORDS  = 16,
  parameter int unsigned COEF_WORDS = 256,
  parameter int unsigned ZERO_RUN   = 800,
  parameter int unsigned CLR_CYCLES = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic                          frame_i,
  input  logic                          host_rst_n_i,
  input  logic                          word_vld_i,
  input  logic [SAMP_W-1:0]             samp_l_i,
  input  logic [SAMP_W-1:0]             samp_r_i,
  output logic                          in_ready_o,
  output logic                          mem_clr_o,
  output logic                          samp_clr_o,
  output logic                          grp_ld_en_o,
  output logic                          coef_ld_en_o,
  output logic                          compute_en_o,
  output logic [$clog2(COEF_WORDS)-1:0] ld_idx_o,
  output logic [3:0]                    mode_o
);

  localparam int unsigned IDX_W = $clog2(COEF_WORDS);
  localparam logic [IDX_W-1:0] GRP_LAST  = IDX_W'(GRP_WORDS - 1);
  localparam logic [IDX_W-1:0] COEF_LAST = IDX_W'(COEF_WORDS - 1);

  logic rst_sync_n;

  amc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // per-channel zero detection
  logic [NUM_CH-1:0][SAMP_W-1:0] samp;
  logic [NUM_CH-1:0]             ch_nz;
  logic                          any_nz;

  assign samp[0] = samp_l_i;
  assign samp[1] = samp_r_i;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign ch_nz[ch] = |samp[ch];
  end

  assign any_nz = |ch_nz;

  mode_e state_q, state_d;

  // clearing sequence
  logic clr_busy, clr_done;

  amc_clear_seq #(.CLR_CYCLES(CLR_CYCLES)) u_clear (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .arm_i   (state_q == MD_INIT),
    .start_i (start_i),
    .busy_o  (clr_busy),
    .done_o  (clr_done)
  );

  // shared load index
  logic             idx_clr, idx_inc;
  logic [IDX_W-1:0] idx;

  assign idx_clr = (state_q == MD_WAIT_GRP) || (state_q == MD_WAIT_COEF);
  assign idx_inc = word_vld_i &&
                   ((state_q == MD_LOAD_GRP) || (state_q == MD_LOAD_COEF));

  amc_word_count #(.IDX_W(IDX_W)) u_idx (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr_i (idx_clr),
    .inc_i (idx_inc),
    .idx_o (idx)
  );

  // silence run
  logic zero_hit;

  amc_zero_run #(.ZERO_RUN(ZERO_RUN)) u_zero (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .active_i (state_q == MD_RUN),
    .vld_i    (word_vld_i),
    .silent_i (!any_nz),
    .hit_o    (zero_hit)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MD_INIT:      if (clr_done) state_d = MD_WAIT_GRP;
      MD_WAIT_GRP:  if (frame_i) state_d = MD_LOAD_GRP;
      MD_LOAD_GRP:  if (word_vld_i && idx == GRP_LAST) state_d = MD_WAIT_COEF;
      MD_WAIT_COEF: if (frame_i) state_d = MD_LOAD_COEF;
      MD_LOAD_COEF: if (word_vld_i && idx == COEF_LAST) state_d = MD_WAIT_DATA;
      MD_WAIT_DATA: begin
        if (!host_rst_n_i) state_d = MD_HOLD;
        else if (frame_i)  state_d = MD_RUN;
      end
      MD_RUN: begin
        if (!host_rst_n_i) state_d = MD_HOLD;
        else if (zero_hit) state_d = MD_SLEEP;
      end
      MD_HOLD:      if (host_rst_n_i) state_d = MD_WAIT_DATA;
      MD_SLEEP: begin
        if (!host_rst_n_i)             state_d = MD_HOLD;
        else if (word_vld_i && any_nz) state_d = MD_RUN;
      end
      default:      state_d = MD_INIT;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= MD_INIT;
    else             state_q <= state_d;
  end

  // mode-decoded outputs
  assign in_ready_o   = (state_q != MD_INIT) && (state_q != MD_HOLD);
  assign mem_clr_o    = clr_busy;
  assign samp_clr_o   = (state_q == MD_HOLD);
  assign grp_ld_en_o  = (state_q == MD_LOAD_GRP);
  assign coef_ld_en_o = (state_q == MD_LOAD_COEF);
  assign compute_en_o = (state_q == MD_RUN);
  assign ld_idx_o     = idx;
  assign mode_o       = state_q;

  // checks
  assert_ready_low_clear_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_clr_o |-> !in_ready_o)
    else $error("ready raised while clearing");

  assert_grp_idx_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == MD_LOAD_GRP) |-> (idx < IDX_W'(GRP_WORDS)))
    else $error("group index past table end");

  assert_coef_done_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == MD_LOAD_COEF && word_vld_i && idx == COEF_LAST) |=> (state_q == MD_WAIT_DATA))
    else $error("coefficient load did not finish");

  assert_soft_entry_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((state_q == MD_WAIT_DATA || state_q == MD_RUN || state_q == MD_SLEEP) && !host_rst_n_i)
      |=> (state_q == MD_HOLD))
    else $error("soft reset not taken");

  assert_soft_hold_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == MD_HOLD) |-> !mem_clr_o)
    else $error("tables cleared by soft reset");

  assert_load_ignore_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q inside {MD_INIT, MD_WAIT_GRP, MD_LOAD_GRP, MD_WAIT_COEF, MD_LOAD_COEF})
      |=> (state_q != MD_HOLD))
    else $error("soft reset acted during set-up");

  assert_sleep_cause_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == MD_SLEEP && $past(state_q) == MD_RUN) |-> $past(word_vld_i && !any_nz))
    else $error("sleep entered without silent word");

  assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == MD_SLEEP && host_rst_n_i && word_vld_i && any_nz) |=> (state_q == MD_RUN))
    else $error("nonzero word did not wake");

endmodule

// File: tb/audio_mode_ctrl_bench.sv
`timescale 1ns/1ps
module audio_mode_ctrl_bench;

  localparam int SAMP_W = 16;
  localparam int GRP_N  = 16;
  localparam int COEF_N = 256;
  localparam int ZRUN   = 800;
  localparam int CLR_N  = 256;

  logic        clk = 1'b0;
  logic        rst_n, start, frame, host_rst_n, word_vld;
  logic [15:0] samp_l, samp_r;
  logic        in_ready, mem_clr, samp_clr, grp_ld_en, coef_ld_en, compute_en;
  logic [7:0]  ld_idx;
  logic [3:0]  mode;

  int n_checks = 0;
  int n_bad    = 0;
  bit timed_out = 1'b0;

  always #4 clk = ~clk;

  audio_mode_ctrl #(
    .SAMP_W(SAMP_W), .GRP_WORDS(GRP_N), .COEF_WORDS(COEF_N),
    .ZERO_RUN(ZRUN), .CLR_CYCLES(CLR_N)
  ) u_audio_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .frame_i(frame),
    .host_rst_n_i(host_rst_n), .word_vld_i(word_vld),
    .samp_l_i(samp_l), .samp_r_i(samp_r),
    .in_ready_o(in_ready), .mem_clr_o(mem_clr), .samp_clr_o(samp_clr),
    .grp_ld_en_o(grp_ld_en), .coef_ld_en_o(coef_ld_en),
    .compute_en_o(compute_en), .ld_idx_o(ld_idx), .mode_o(mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one edge; inputs change and outputs are sampled 1 ns after it
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic strobe(input logic [15:0] l, input logic [15:0] r);
    word_vld = 1'b1; samp_l = l; samp_r = r;
    cyc();
    word_vld = 1'b0; samp_l = '0; samp_r = '0;
  endtask

  task automatic pulse_frame();
    frame = 1'b1;
    cyc();
    frame = 1'b0;
  endtask

  task automatic t_reset_R1();
    rst_n = 1'b0; start = 0; frame = 0; host_rst_n = 1; word_vld = 0;
    samp_l = '0; samp_r = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();
    chk("R1 mode", mode, 0);
    chk("R1 in_ready", in_ready, 0);
    chk("R1 mem_clr", mem_clr, 0);
    chk("R1 enables", {samp_clr, grp_ld_en, coef_ld_en, compute_en}, 0);
  endtask

  task automatic t_init_R2();
    int n_clr = 0;
    bit rdy_seen = 1'b0;
    host_rst_n = 1'b0;             // R7: ignored in mode 0
    start = 1'b1;
    cyc();
    start = 1'b0;
    while (mem_clr && n_clr < 1000) begin
      if (in_ready) rdy_seen = 1'b1;
      n_clr++;
      cyc();
    end
    host_rst_n = 1'b1;
    chk("R2 clear length", n_clr, CLR_N);
    chk("R2 ready low while clearing", rdy_seen, 0);
    chk("R2 mode after clear", mode, 1);
    chk("R2 ready after clear", in_ready, 1);
  endtask

  task automatic t_load_grp_R3();
    pulse_frame();
    chk("R3 mode load groups", mode, 2);
    chk("R3 group enable", grp_ld_en, 1);
    for (int i = 0; i < GRP_N; i++) begin
      chk("R3 index", ld_idx, i);
      host_rst_n = (i >= 4 && i < 8) ? 1'b0 : 1'b1;   // R7
      strobe(16'(i), 16'(i));
      if (i == 7) chk("R7 soft reset ignored in load", mode, 2);
    end
    host_rst_n = 1'b1;
    chk("R3 mode after groups", mode, 3);
    chk("R3 group enable off", grp_ld_en, 0);
  endtask

  task automatic t_load_coef_R4();
    pulse_frame();
    chk("R4 mode load coefs", mode, 4);
    chk("R4 coef enable", coef_ld_en, 1);
    for (int i = 0; i < COEF_N; i++) begin
      if (ld_idx != 8'(i)) chk("R4 index", ld_idx, i);
      host_rst_n = (i == 100) ? 1'b0 : 1'b1;          // R7
      strobe(16'hA5A5, 16'h5A5A);
      if (i == 100) chk("R7 index continues", ld_idx, 101);
      if (i == COEF_N - 2) chk("R4 not done one early", mode, 4);
    end
    host_rst_n = 1'b1;
    chk("R4 mode after coefs", mode, 5);
    chk("R5 ready in wait-data", in_ready, 1);
  endtask

  task automatic t_run_R5();
    pulse_frame();
    chk("R5 mode run", mode, 6);
    chk("R5 compute enable", compute_en, 1);
    chk("R5 ready in run", in_ready, 1);
  endtask

  task automatic t_sleep_R8();
    for (int i = 0; i < ZRUN - 1; i++) strobe('0, '0);
    strobe(16'h0001, '0);
    chk("R8 799 zeros stay run", mode, 6);
    for (int i = 0; i < ZRUN - 1; i++) strobe('0, '0);
    chk("R8 799 after restart", mode, 6);
    strobe('0, '0);
    chk("R8 800th zero sleeps", mode, 8);
  endtask

  task automatic t_wake_R9();
    chk("R9 compute off in sleep", compute_en, 0);
    chk("R9 ready in sleep", in_ready, 1);
    repeat (5) strobe('0, '0);
    chk("R9 zeros keep sleep", mode, 8);
    strobe('0, 16'h8000);
    chk("R9 right nonzero wakes", mode, 6);
  endtask

  task automatic t_soft_R6();
    host_rst_n = 1'b0;
    frame = 1'b1;
    cyc();
    frame = 1'b0;
    chk("R6 enter hold", mode, 7);
    chk("R6 ready low", in_ready, 0);
    chk("R6 sample clear", samp_clr, 1);
    chk("R6 tables kept", mem_clr, 0);
    repeat (5) cyc();
    chk("R6 stays while low", mode, 7);
    host_rst_n = 1'b1;
    cyc();
    chk("R6 back to wait-data", mode, 5);
    pulse_frame();
    chk("R6 run again", mode, 6);
  endtask

  task automatic t_fresh_run_R10();
    for (int i = 0; i < 500; i++) strobe('0, '0);
    host_rst_n = 1'b0;
    cyc();
    host_rst_n = 1'b1;
    cyc();
    chk("R10 wait-data after reset", mode, 5);
    pulse_frame();
    for (int i = 0; i < 500; i++) strobe('0, '0);
    chk("R10 old silence forgotten", mode, 6);
    for (int i = 0; i < 299; i++) strobe('0, '0);
    chk("R10 one short", mode, 6);
    strobe('0, '0);
    chk("R10 full run sleeps", mode, 8);
    host_rst_n = 1'b0;
    cyc();
    host_rst_n = 1'b1;
    chk("R6 sleep to hold", mode, 7);
    cyc();
    chk("R6 hold to wait-data", mode, 5);
  endtask

  initial begin
    fork
      begin
        t_reset_R1();
        t_init_R2();
        t_load_grp_R3();
        t_load_coef_R4();
        t_run_R5();
        t_sleep_R8();
        t_wake_R9();
        t_soft_R6();
        t_fresh_run_R10();
      end
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    end
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule